// File: doc/BRIEF.md
# Program-Counter Sequencer with Hardware Return Stack

This block steps the program counter of a small RISC core. It divides the oscillator clock into four-phase instruction cycles. At the last phase of each cycle it takes one flow operation from the decoder: sequential advance, jump, call, return, return-with-literal, return-from-interrupt, or a write of the low program-counter byte. A low-byte write is how the core performs a computed table lookup: the ALU adds an index to the low byte, and the table entries are return-with-literal instructions.

Return addresses live in a private eight-entry circular store that holds nothing else. The block owns the global interrupt enable bit. When that bit is set, a pending request is accepted at a cycle boundary. Acceptance saves only the program counter, clears the enable bit and redirects execution to address 0x004. Each non-sequential change of the program counter is followed by one flush cycle, which executes as a no-operation.

Top module: `pc_sequencer`

## Requirements
- R1: `phase_o` counts 0,1,2,3 and repeats, one step per clock. `cyc_last_o` is high exactly in phase 3. Inputs are acted on only at the clock edge that ends phase 3, so `pc_o`, `flush_o` and `gie_o` change only at that edge.
- R2: Reset (synchronous, active high) gives `pc_o`=0, phase 0, `flush_o`=0, `gie_o`=0 and `w_load_o`=0, and clears every stack entry to 0 with the stack pointer at entry 0.
- R3: Op code 0 (sequential), and the unused codes 9 to 15, advance `pc_o` by one, modulo 2^13, with no flush.
- R4: Op code 1 (jump) loads `pc_o` with `target_i`. The next instruction cycle is a flush: `flush_o` is high, its op and `irq_i` are ignored, and `pc_o` holds. Normal execution resumes after it.
- R5: Op code 2 (call) pushes `pc_o`+1 and loads `target_i`. Op code 3 (return) loads `pc_o` with the most recently pushed address. Both are followed by a flush cycle.
- R6: Op code 4 (return with literal) returns like code 3. It also raises `w_load_o` for exactly one clock, in phase 0 of the following cycle, with `w_data_o` equal to the `lit_i` sampled at the boundary.
- R7: Op code 6 (low-byte write) sets bits 7:0 of `pc_o` to `pcl_i`, keeps bits 12:8, and is followed by a flush cycle.
- R8: Op code 7 sets `gie_o`. Op code 8 clears it. Both advance `pc_o` sequentially.
- R9: An interrupt is taken at the end of a non-flush cycle when `irq_i` and `gie_o` are both high. That cycle's op is ignored. The address of that unexecuted instruction (`pc_o`) is pushed, `pc_o` becomes 0x004, `gie_o` clears, and a flush cycle follows. No interrupt is taken while `gie_o` is low or during a flush cycle.
- R10: Op code 5 (return from interrupt) returns like code 3 and sets `gie_o`.
- R11: The stack holds eight entries and is circular. A ninth push overwrites the oldest entry, and a pop with no entries left wraps round to the newest slot. No overflow indication exists.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oscillator clock |
| rst | input | 1 | Synchronous active-high reset |
| op_i | input | 4 | Flow operation code for the current instruction |
| target_i | input | 13 | Jump or call destination |
| lit_i | input | 8 | Literal returned to the working register |
| pcl_i | input | 8 | New low byte of the program counter |
| irq_i | input | 1 | Interrupt request level |
| phase_o | output | 2 | Phase within the instruction cycle |
| cyc_last_o | output | 1 | High in the final phase of a cycle |
| pc_o | output | 13 | Address of the instruction in the current cycle |
| flush_o | output | 1 | Current cycle is a flush (no-operation) |
| gie_o | output | 1 | Global interrupt enable |
| w_load_o | output | 1 | Load strobe for the working register |
| w_data_o | output | 8 | Value to load into the working register |

## Verification
The stack has no visible pointer, so a corrupted pointer or entry shows up only when a return loads a wrong `pc_o`. That happens one clock after the boundary that carries the return, which may be many cycles after the faulty push. For this reason the bench compares each return target against its own model of the stack, including runs of nine calls and nine returns that exercise the wrap. A wrong enable bit or flush flag shows up at the very next boundary: an interrupt is accepted or refused wrongly, or an op that should be ignored is executed. Because of that, every cycle's `pc_o`, `flush_o` and `gie_o` are compared one clock after its boundary.

// File: rtl/pcseq_pkg.sv
package pcseq_pkg;
    localparam int PC_W        = 13;
    localparam int LIT_W       = 8;
    localparam int LOW_W       = 8;
    localparam int STACK_DEPTH = 8;
    localparam int PHASES      = 4;
    localparam logic [PC_W-1:0] IRQ_VECTOR = 13'h004;

    typedef enum logic [3:0] {
        FL_SEQ    = 4'd0,
        FL_JUMP   = 4'd1,
        FL_CALL   = 4'd2,
        FL_RET    = 4'd3,
        FL_RETLIT = 4'd4,
        FL_RETINT = 4'd5,
        FL_LOWWR  = 4'd6,
        FL_IE_ON  = 4'd7,
        FL_IE_OFF = 4'd8
    } flow_op_e;

    typedef struct packed {
        logic [PC_W-1:0] pc;
        logic            flush;
        logic            gie;
    } seq_state_t;

    function automatic logic [PC_W-1:0] pc_next(input logic [PC_W-1:0] pc);
        return pc + {{(PC_W-1){1'b0}}, 1'b1};
    endfunction

    function automatic logic [PC_W-1:0] pc_low_merge(input logic [PC_W-1:0] pc,
                                                     input logic [LOW_W-1:0] low);
        return {pc[PC_W-1:LOW_W], low};
    endfunction
endpackage

// File: rtl/seq_phase_gen.sv
module seq_phase_gen #(
    parameter int PHASES = 4,
    localparam int PH_W = $clog2(PHASES)
) (
    input  logic            clk,
    input  logic            rst,
    output logic [PH_W-1:0] phase,
    output logic            last
);
    localparam logic [PH_W-1:0] PH_MAX = PH_W'(PHASES - 1);

    logic [PH_W-1:0] ph_q;

    always_ff @(posedge clk) begin
        if (rst)                ph_q <= '0;
        else if (ph_q == PH_MAX) ph_q <= '0;
        else                    ph_q <= ph_q + 1'b1;
    end

    assign phase = ph_q;
    assign last  = (ph_q == PH_MAX);

    p_phase_wrap_r1: assert property (@(posedge clk) disable iff (rst)
        last |=> (phase == '0));
endmodule

// File: rtl/seq_ret_stack.sv
module seq_ret_stack #(
    parameter int DEPTH = 8,
    parameter int WIDTH = 13,
    localparam int PTR_W = $clog2(DEPTH)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             push,
    input  logic             pop,
    input  logic [WIDTH-1:0] din,
    output logic [WIDTH-1:0] dout
);
    localparam logic [PTR_W-1:0] PTR_LAST = PTR_W'(DEPTH - 1);

    logic [WIDTH-1:0] mem [DEPTH];
    logic [PTR_W-1:0] ptr_q;
    logic [PTR_W-1:0] ptr_up;
    logic [PTR_W-1:0] ptr_dn;

    assign ptr_up = (ptr_q == PTR_LAST) ? '0 : ptr_q + 1'b1;
    assign ptr_dn = (ptr_q == '0) ? PTR_LAST : ptr_q - 1'b1;
    assign dout   = mem[ptr_dn];

    always_ff @(posedge clk) begin
        if (rst) begin
            ptr_q <= '0;
            for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
        end else if (push) begin
            mem[ptr_q] <= din;
            ptr_q      <= ptr_up;
        end else if (pop) begin
            ptr_q <= ptr_dn;
        end
    end

    always_comb begin
        a_no_push_pop_r11: assert (rst !== 1'b0 || !(push && pop));
    end

    p_ptr_idle_r11: assert property (@(posedge clk) disable iff (rst)
        (!push && !pop) |=> $stable(ptr_q));
endmodule

// File: rtl/pc_sequencer.sv
module pc_sequencer
    import pcseq_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic [3:0]       op_i,
    input  logic [PC_W-1:0]  target_i,
    input  logic [LIT_W-1:0] lit_i,
    input  logic [LOW_W-1:0] pcl_i,
    input  logic             irq_i,
    output logic [1:0]       phase_o,
    output logic             cyc_last_o,
    output logic [PC_W-1:0]  pc_o,
    output logic             flush_o,
    output logic             gie_o,
    output logic             w_load_o,
    output logic [LIT_W-1:0] w_data_o
);
    localparam int PH_W = $clog2(PHASES);

    seq_state_t       st_q;
    flow_op_e         op;
    logic [PH_W-1:0]  phase;
    logic             cyc_last;
    logic             take_irq;
    logic             exec;
    logic             is_pop;
    logic             push;
    logic             pop;
    logic [PC_W-1:0]  push_data;
    logic [PC_W-1:0]  stack_top;
    logic             w_load_q;
    logic [LIT_W-1:0] w_data_q;

    seq_phase_gen #(.PHASES(PHASES)) u_phase (
        .clk  (clk),
        .rst  (rst),
        .phase(phase),
        .last (cyc_last)
    );

    assign op       = flow_op_e'(op_i);
    assign take_irq = cyc_last && !st_q.flush && irq_i && st_q.gie;
    assign exec     = cyc_last && !st_q.flush && !take_irq;
    assign is_pop   = (op == FL_RET) || (op == FL_RETLIT) || (op == FL_RETINT);
    assign push     = take_irq || (exec && op == FL_CALL);
    assign pop      = exec && is_pop;
    assign push_data = take_irq ? st_q.pc : pc_next(st_q.pc);

    seq_ret_stack #(.DEPTH(STACK_DEPTH), .WIDTH(PC_W)) u_stack (
        .clk (clk),
        .rst (rst),
        .push(push),
        .pop (pop),
        .din (push_data),
        .dout(stack_top)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q <= '{pc: '0, flush: 1'b0, gie: 1'b0};
        end else if (cyc_last) begin
            if (st_q.flush) begin
                st_q.flush <= 1'b0;
            end else if (take_irq) begin
                st_q.pc    <= IRQ_VECTOR;
                st_q.gie   <= 1'b0;
                st_q.flush <= 1'b1;
            end else begin
                case (op)
                    FL_JUMP, FL_CALL: begin
                        st_q.pc    <= target_i;
                        st_q.flush <= 1'b1;
                    end
                    FL_RET, FL_RETLIT: begin
                        st_q.pc    <= stack_top;
                        st_q.flush <= 1'b1;
                    end
                    FL_RETINT: begin
                        st_q.pc    <= stack_top;
                        st_q.gie   <= 1'b1;
                        st_q.flush <= 1'b1;
                    end
                    FL_LOWWR: begin
                        st_q.pc    <= pc_low_merge(st_q.pc, pcl_i);
                        st_q.flush <= 1'b1;
                    end
                    FL_IE_ON: begin
                        st_q.pc  <= pc_next(st_q.pc);
                        st_q.gie <= 1'b1;
                    end
                    FL_IE_OFF: begin
                        st_q.pc  <= pc_next(st_q.pc);
                        st_q.gie <= 1'b0;
                    end
                    default: st_q.pc <= pc_next(st_q.pc);
                endcase
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            w_load_q <= 1'b0;
            w_data_q <= '0;
        end else begin
            w_load_q <= exec && (op == FL_RETLIT);
            if (exec && op == FL_RETLIT) w_data_q <= lit_i;
        end
    end

    assign phase_o    = 2'(phase);
    assign cyc_last_o = cyc_last;
    assign pc_o       = st_q.pc;
    assign flush_o    = st_q.flush;
    assign gie_o      = st_q.gie;
    assign w_load_o   = w_load_q;
    assign w_data_o   = w_data_q;

    p_pc_boundary_r1: assert property (@(posedge clk) disable iff (rst)
        !cyc_last |=> ($stable(st_q.pc) && $stable(st_q.gie) && $stable(st_q.flush)));

    p_flush_once_r4: assert property (@(posedge clk) disable iff (rst)
        (cyc_last && st_q.flush) |=> !st_q.flush);

    p_wload_pulse_r6: assert property (@(posedge clk) disable iff (rst)
        w_load_q |=> !w_load_q);

    p_irq_entry_r9: assert property (@(posedge clk) disable iff (rst)
        take_irq |=> (!st_q.gie && st_q.flush && st_q.pc == IRQ_VECTOR));

    p_no_irq_masked_r9: assert property (@(posedge clk) disable iff (rst)
        (cyc_last && !st_q.gie && !st_q.flush && op == FL_SEQ) |=> (st_q.pc == $past(pc_next(st_q.pc))));
endmodule

// File: tb/tb_pc_sequencer.sv
module tb_pc_sequencer;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [3:0]  op_i = 4'd0;
    logic [12:0] target_i = '0;
    logic [7:0]  lit_i = '0;
    logic [7:0]  pcl_i = '0;
    logic        irq_i = 1'b0;
    logic [1:0]  phase_o;
    logic        cyc_last_o;
    logic [12:0] pc_o;
    logic        flush_o;
    logic        gie_o;
    logic        w_load_o;
    logic [7:0]  w_data_o;

    int checks = 0;
    int errors = 0;
    bit done   = 0;

    logic [12:0] m_pc;
    logic        m_flush;
    logic        m_gie;
    logic [12:0] m_stk [8];
    int          m_ptr;

    pc_sequencer dut (
        .clk(clk), .rst(rst), .op_i(op_i), .target_i(target_i), .lit_i(lit_i),
        .pcl_i(pcl_i), .irq_i(irq_i), .phase_o(phase_o), .cyc_last_o(cyc_last_o),
        .pc_o(pc_o), .flush_o(flush_o), .gie_o(gie_o), .w_load_o(w_load_o),
        .w_data_o(w_data_o)
    );

    always #5 clk = ~clk;

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    function automatic logic [12:0] inc13(input logic [12:0] v);
        return v + 13'd1;
    endfunction

    task automatic m_push(input logic [12:0] v);
        m_stk[m_ptr] = v;
        m_ptr = (m_ptr + 1) % 8;
    endtask

    function automatic logic [12:0] m_pop();
        m_ptr = (m_ptr + 7) % 8;
        return m_stk[m_ptr];
    endfunction

    // entered at a negedge in phase 3
    task automatic step(input logic [3:0] op, input logic [12:0] tgt, input logic [7:0] lit,
                        input logic [7:0] pcl, input logic irq, input string tag);
        bit exp_wl;
        exp_wl = 0;
        op_i = op; target_i = tgt; lit_i = lit; pcl_i = pcl; irq_i = irq;
        if (m_flush) begin
            m_flush = 0;
        end else if (irq && m_gie) begin
            m_push(m_pc); m_pc = 13'h004; m_gie = 0; m_flush = 1;
        end else begin
            case (op)
                4'd1: begin m_pc = tgt; m_flush = 1; end
                4'd2: begin m_push(inc13(m_pc)); m_pc = tgt; m_flush = 1; end
                4'd3: begin m_pc = m_pop(); m_flush = 1; end
                4'd4: begin m_pc = m_pop(); m_flush = 1; exp_wl = 1; end
                4'd5: begin m_pc = m_pop(); m_flush = 1; m_gie = 1; end
                4'd6: begin m_pc = {m_pc[12:8], pcl}; m_flush = 1; end
                4'd7: begin m_pc = inc13(m_pc); m_gie = 1; end
                4'd8: begin m_pc = inc13(m_pc); m_gie = 0; end
                default: m_pc = inc13(m_pc);
            endcase
        end
        @(posedge clk);
        @(negedge clk);
        op_i = 4'd0; irq_i = 1'b0;
        chk(phase_o == 2'd0 && !cyc_last_o, "R1 phase0", int'(phase_o), 0);
        chk(w_load_o == exp_wl, "R6 w_load", int'(w_load_o), int'(exp_wl));
        if (exp_wl) chk(w_data_o == lit, "R6 w_data", int'(w_data_o), int'(lit));
        chk(pc_o == m_pc, {tag, " pc"}, int'(pc_o), int'(m_pc));
        chk(flush_o == m_flush, {tag, " flush"}, int'(flush_o), int'(m_flush));
        chk(gie_o == m_gie, {tag, " gie"}, int'(gie_o), int'(m_gie));
        @(negedge clk);
        chk(w_load_o == 1'b0, "R6 pulse width", int'(w_load_o), 0);
        repeat (2) @(negedge clk);
        chk(phase_o == 2'd3 && cyc_last_o, "R1 phase3", int'(phase_o), 3);
        chk(pc_o == m_pc, "R1 pc held", int'(pc_o), int'(m_pc));
    endtask

    initial begin
        int n;
        repeat (20000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog expired actual=1 expected=0");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'h5EED_0C0D));
        m_pc = '0; m_flush = 0; m_gie = 0; m_ptr = 0;
        for (int i = 0; i < 8; i++) m_stk[i] = '0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        chk(pc_o == 13'd0, "R2 pc", int'(pc_o), 0);
        chk(phase_o == 2'd0, "R2 phase", int'(phase_o), 0);
        chk(!flush_o && !gie_o && !w_load_o, "R2 flags",
            int'({flush_o, gie_o, w_load_o}), 0);
        @(negedge clk);
        chk(phase_o == 2'd1 && !cyc_last_o, "R1 phase1", int'(phase_o), 1);
        @(negedge clk);
        chk(phase_o == 2'd2, "R1 phase2", int'(phase_o), 2);
        @(negedge clk);

        step(4'd0, 13'h1AAA, 8'h00, 8'h00, 1'b0, "R3");
        step(4'd0, 13'h0000, 8'h00, 8'h00, 1'b0, "R3");
        step(4'd11, 13'h0F0F, 8'h00, 8'h00, 1'b0, "R3 unused code");
        step(4'd1, 13'h0123, 8'h00, 8'h00, 1'b0, "R4 jump");
        chk(pc_o == 13'h0123, "R4 target", int'(pc_o), 'h123);
        step(4'd1, 13'h0555, 8'h00, 8'h00, 1'b0, "R4 op in flush ignored");
        chk(pc_o == 13'h0123, "R4 flush hold", int'(pc_o), 'h123);
        step(4'd2, 13'h0200, 8'h00, 8'h00, 1'b0, "R5 call");
        step(4'd0, 13'h0000, 8'h00, 8'h00, 1'b0, "R5 flush");
        step(4'd3, 13'h0000, 8'h00, 8'h00, 1'b0, "R5 return");
        chk(pc_o == 13'h0124, "R5 return addr", int'(pc_o), 'h124);
        step(4'd0, 13'h0000, 8'h00, 8'h00, 1'b0, "R5 flush");
        step(4'd2, 13'h1300, 8'h00, 8'h00, 1'b0, "R6 call");
        step(4'd0, 13'h0000, 8'h00, 8'h00, 1'b0, "R6 flush");
        step(4'd4, 13'h0000, 8'hA5, 8'h00, 1'b0, "R6 retlit");
        step(4'd0, 13'h0000, 8'h00, 8'h00, 1'b0, "R6 flush");
        step(4'd6, 13'h0000, 8'h00, 8'h7E, 1'b0, "R7 low write");
        step(4'd0, 13'h0000, 8'h00, 8'h00, 1'b0, "R7 flush");
        step(4'd0, 13'h0000, 8'h00, 8'h00, 1'b1, "R9 masked irq");
        step(4'd7, 13'h0000, 8'h00, 8'h00, 1'b0, "R8 enable");
        step(4'd1, 13'h0A00, 8'h00, 8'h00, 1'b0, "R9 jump");
        step(4'd0, 13'h0000, 8'h00, 8'h00, 1'b1, "R9 irq in flush");
        step(4'd1, 13'h0777, 8'h00, 8'h00, 1'b1, "R9 irq taken");
        chk(pc_o == 13'h004 && !gie_o, "R9 vector", int'(pc_o), 4);
        step(4'd0, 13'h0000, 8'h00, 8'h00, 1'b0, "R9 flush");
        step(4'd5, 13'h0000, 8'h00, 8'h00, 1'b0, "R10 retint");
        chk(pc_o == 13'h0A00 && gie_o, "R10 resume", int'(pc_o), 'hA00);
        step(4'd0, 13'h0000, 8'h00, 8'h00, 1'b0, "R10 flush");
        step(4'd8, 13'h0000, 8'h00, 8'h00, 1'b0, "R8 disable");
        for (int i = 0; i < 9; i++) begin
            step(4'd2, 13'(16'h0100 * (i + 1)), 8'h00, 8'h00, 1'b0, "R11 deep call");
            step(4'd0, 13'h0000, 8'h00, 8'h00, 1'b0, "R11 flush");
        end
        for (int i = 0; i < 9; i++) begin
            step(4'd3, 13'h0000, 8'h00, 8'h00, 1'b0, "R11 deep return");
            step(4'd0, 13'h0000, 8'h00, 8'h00, 1'b0, "R11 flush");
        end
        for (int i = 0; i < 400; i++) begin
            logic [3:0] rop;
            rop = 4'($urandom % 16);
            step(rop, 13'($urandom), 8'($urandom), 8'($urandom),
                 (($urandom % 6) == 0), "R3 R5 R9 random");
        end
        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule